// File: doc/BRIEF.md
# Geometry Command Queue Status and Interrupt Register

This block is the 32-bit status and control word that software reads and writes to follow the progress of a geometry command queue. It does not contain the queue. It takes the queue occupancy, a flag saying that a command is executing and a flag saying that a buffer swap is waiting, and turns them into a reported entry count plus below-half, empty and busy flags. A swap that is waiting counts as one extra entry. A swap wait also keeps the block busy.

The word also carries a sticky matrix-stack error flag and a one-bit projection-stack level. External pulses set both. Software clears both with a single write. A two-bit interrupt mode chooses when a level interrupt request is raised: while the count is below half the queue depth, or only when the queue has drained. The request is registered and follows its condition every cycle.

Top module: `geo_queue_status`

## Requirements
- R1: Bits [24:16] of `rd_data` read as `q_count` plus one while `swap_pend` is high, and as `q_count` otherwise (so 256 plus a waiting swap reads 257).
- R2: Bit 25 of `rd_data` is 1 exactly when the reported count is below 128. Bit 26 is 1 exactly when the reported count is zero.
- R3: Bit 27 of `rd_data` (busy) is 1 exactly when `exec_busy` or `swap_pend` is high.
- R4: A write with `wr_half[1]` set loads `wr_data[31:30]` into the mode field read at bits [31:30]. Every other bit of the upper half ignores writes. Without such a write the mode field keeps its value.
- R5: `irq` is a registered level. One clock after a cycle in which the mode was 1 and the count was below 128, or the mode was 2 and the count was zero, `irq` is 1. Otherwise it is 0, and mode 0 and mode 3 never raise it.
- R6: An `err_set` pulse sets the error flag at bit 15, and the flag holds until software clears it. An `lvl_load` pulse loads `lvl_value` into the level bit at bit 14.
- R7: A write with `wr_half[0]` set and `wr_data[15]` = 1 clears both bit 15 and bit 14. A low-half write with `wr_data[15]` = 0 changes nothing. When `err_set` or `lvl_load` arrives in the same cycle as the clear, the set or load wins for its own bit.
- R8: After reset the mode is 0, bits 15 and 14 are 0, and `irq` is 0.
- R9: Bits [13:0], 28 and 29 of `rd_data` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_half | input | 2 | Half enables: bit 0 low 16 bits, bit 1 high 16 bits |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current status word (combinational) |
| q_count | input | 9 | Live queue occupancy, 0 to 256 |
| exec_busy | input | 1 | A command is executing |
| swap_pend | input | 1 | A buffer swap is waiting |
| err_set | input | 1 | Pulse that sets the stack error flag |
| lvl_load | input | 1 | Pulse that loads the projection level |
| lvl_value | input | 1 | Level value taken on `lvl_load` |
| irq | output | 1 | Registered interrupt request level |

## Verification
Random occupancy, swap and execute flags are mixed with random mode writes. This tells apart a count that includes the swap from one that ignores it, and checks each mode against each threshold. Directed steps hold the count at 127, 128, 0 and 257. These separate a below-half test from a less-or-equal test, and show that an empty queue with a waiting swap is neither empty nor a mode-2 interrupt. Error and level pulses are sent alone, against a clearing write with bit 15 = 0, and in the same cycle as a clearing write. This shows that the flags are sticky, which writes clear them, and that a set arriving in the same cycle as a clear wins.

// File: rtl/geoq_pkg.sv
package geoq_pkg;

    localparam int GQ_DEPTH = 256;
    localparam int GQ_CNT_W = $clog2(GQ_DEPTH + 2);
    localparam int GQ_HALF  = GQ_DEPTH / 2;

    typedef enum logic [1:0] {
        IRQ_OFF   = 2'd0,
        IRQ_HALF  = 2'd1,
        IRQ_EMPTY = 2'd2,
        IRQ_RSVD  = 2'd3
    } irq_mode_e;

    // Status word, MSB first.
    typedef struct packed {
        irq_mode_e           mode;
        logic [1:0]          zero_hi;
        logic                busy;
        logic                empty;
        logic                lt_half;
        logic [GQ_CNT_W-1:0] count;
        logic                stk_err;
        logic                proj_lvl;
        logic [13:0]         zero_lo;
    } status_t;

    function automatic logic irq_wanted(irq_mode_e m, logic lt_half, logic empty);
        case (m)
            IRQ_HALF:  irq_wanted = lt_half;
            IRQ_EMPTY: irq_wanted = empty;
            default:   irq_wanted = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/geoq_level_calc.sv
module geoq_level_calc #(
    parameter int CNT_W = 9,
    parameter int HALF  = 128
) (
    input  logic [CNT_W-1:0] q_count,
    input  logic             swap_pend,
    input  logic             exec_busy,
    output logic [CNT_W-1:0] count,
    output logic             lt_half,
    output logic             empty,
    output logic             busy
);
    always_comb begin
        count   = q_count + CNT_W'(swap_pend);
        lt_half = (count < CNT_W'(HALF));
        empty   = (count == '0);
        busy    = exec_busy | swap_pend;
    end
endmodule

// File: rtl/geoq_err_hold.sv
module geoq_err_hold (
    input  logic clk,
    input  logic rst,
    input  logic err_set,
    input  logic lvl_load,
    input  logic lvl_value,
    input  logic clr,
    output logic stk_err,
    output logic proj_lvl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stk_err  <= 1'b0;
            proj_lvl <= 1'b0;
        end else begin
            if (err_set)  stk_err <= 1'b1;
            else if (clr) stk_err <= 1'b0;
            if (lvl_load) proj_lvl <= lvl_value;
            else if (clr) proj_lvl <= 1'b0;
        end
    end
endmodule

// File: rtl/geoq_irq_gen.sv
module geoq_irq_gen
    import geoq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_wr,
    input  logic [1:0] mode_in,
    input  logic       lt_half,
    input  logic       empty,
    output irq_mode_e  mode,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= IRQ_OFF;
            irq  <= 1'b0;
        end else begin
            if (mode_wr) mode <= irq_mode_e'(mode_in);
            irq <= irq_wanted(mode, lt_half, empty);
        end
    end
endmodule

// File: rtl/geo_queue_status.sv
module geo_queue_status
    import geoq_pkg::*;
#(
    parameter int CNT_W = GQ_CNT_W,
    parameter int HALF  = GQ_HALF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_half,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    input  logic [CNT_W-1:0] q_count,
    input  logic             exec_busy,
    input  logic             swap_pend,
    input  logic             err_set,
    input  logic             lvl_load,
    input  logic             lvl_value,
    output logic             irq
);
    logic [CNT_W-1:0] count;
    logic             lt_half, empty, busy, stk_err, proj_lvl;
    logic             clr_err, mode_wr;
    irq_mode_e        mode;
    status_t          st;

    assign clr_err = wr_en & wr_half[0] & wr_data[15];
    assign mode_wr = wr_en & wr_half[1];

    geoq_level_calc #(.CNT_W(CNT_W), .HALF(HALF)) u_lvl (
        .q_count(q_count), .swap_pend(swap_pend), .exec_busy(exec_busy),
        .count(count), .lt_half(lt_half), .empty(empty), .busy(busy)
    );

    geoq_err_hold u_err (
        .clk(clk), .rst(rst), .err_set(err_set), .lvl_load(lvl_load),
        .lvl_value(lvl_value), .clr(clr_err),
        .stk_err(stk_err), .proj_lvl(proj_lvl)
    );

    geoq_irq_gen u_irq (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_in(wr_data[31:30]),
        .lt_half(lt_half), .empty(empty), .mode(mode), .irq(irq)
    );

    always_comb begin
        st          = '0;
        st.mode     = mode;
        st.busy     = busy;
        st.empty    = empty;
        st.lt_half  = lt_half;
        st.count    = GQ_CNT_W'(count);
        st.stk_err  = stk_err;
        st.proj_lvl = proj_lvl;
        rd_data     = st;
    end
endmodule

// File: rtl/geoq_status_chk.sv
module geoq_status_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_half,
    input logic [31:0] wr_data,
    input logic        err_set,
    input logic [31:0] rd_data,
    input logic        irq
);
    p_empty_below_half_r2: assert property (@(posedge clk) disable iff (rst)
        rd_data[26] |-> rd_data[25]);

    p_mode_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_half[1]) |=> $stable(rd_data[31:30]));

    p_irq_track_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq == (($past(rd_data[31:30]) == 2'd1 && $past(rd_data[25])) ||
                         ($past(rd_data[31:30]) == 2'd2 && $past(rd_data[26]))));

    p_err_set_r6: assert property (@(posedge clk) disable iff (rst)
        err_set |=> rd_data[15]);

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        rd_data[15] && !(wr_en && wr_half[0] && wr_data[15]) |=> rd_data[15]);

    p_err_clear_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_half[0] && wr_data[15] && !err_set |=> !rd_data[15]);

    p_reserved_r9: assert property (@(posedge clk) disable iff (rst)
        rd_data[13:0] == 14'd0 && rd_data[29:28] == 2'd0);
endmodule

bind geo_queue_status geoq_status_chk u_chk (.*);

// File: tb/sim_geo_queue_status.sv
module sim_geo_queue_status;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_half = 2'b00;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [8:0]  q_count = '0;
    logic        exec_busy = 1'b0, swap_pend = 1'b0;
    logic        err_set = 1'b0, lvl_load = 1'b0, lvl_value = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [1:0] m_mode = 2'd0;
    logic       m_err = 1'b0, m_lvl = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    geo_queue_status u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_count(logic [8:0] q, logic s);
        return q + {8'd0, s};
    endfunction

    function automatic logic exp_irq(logic [1:0] m, logic [8:0] c);
        return (m == 2'd1 && c < 9'd128) || (m == 2'd2 && c == 9'd0);
    endfunction

    task automatic step(logic [8:0] qc, logic sw, logic ex, logic es, logic ll,
                        logic lv, logic we, logic [1:0] wh, logic [31:0] wd);
        logic [8:0] c;
        logic       ei;
        @(negedge clk);
        q_count = qc; swap_pend = sw; exec_busy = ex;
        err_set = es; lvl_load = ll; lvl_value = lv;
        wr_en = we; wr_half = wh; wr_data = wd;
        #1;
        c = exp_count(qc, sw);
        check("R1 count", 32'(rd_data[24:16]), 32'(c));
        check("R2 below-half", 32'(rd_data[25]), 32'(c < 9'd128));
        check("R2 empty", 32'(rd_data[26]), 32'(c == 9'd0));
        check("R3 busy", 32'(rd_data[27]), 32'(ex | sw));
        check("R4 mode", 32'(rd_data[31:30]), 32'(m_mode));
        check("R6 error", 32'(rd_data[15]), 32'(m_err));
        check("R6 level", 32'(rd_data[14]), 32'(m_lvl));
        check("R9 zero bits", {rd_data[29:28], rd_data[13:0]}, 32'd0);
        ei = exp_irq(m_mode, c);
        @(posedge clk);
        #1;
        if (we && wh[1]) m_mode = wd[31:30];
        if (es) m_err = 1'b1;
        else if (we && wh[0] && wd[15]) m_err = 1'b0;
        if (ll) m_lvl = lv;
        else if (we && wh[0] && wd[15]) m_lvl = 1'b0;
        check("R5 irq", 32'(irq), 32'(ei));
        check("R7 error after write", 32'(rd_data[15]), 32'(m_err));
        check("R7 level after write", 32'(rd_data[14]), 32'(m_lvl));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R8 reset state
        #1;
        check("R8 mode", 32'(rd_data[31:30]), 32'd0);
        check("R8 error/level", 32'(rd_data[15:14]), 32'd0);
        check("R8 irq", 32'(irq), 32'd0);
        // R4 mode 1, count boundary 127/128
        step(9'd5, 0, 0, 0, 0, 0, 1, 2'b10, 32'h4FFF_0000);
        step(9'd127, 0, 1, 0, 0, 0, 0, 2'b00, 0);
        step(9'd128, 0, 1, 0, 0, 0, 0, 2'b00, 0);
        step(9'd127, 1, 0, 0, 0, 0, 0, 2'b00, 0);
        // mode 2, empty and empty-with-swap
        step(9'd0, 0, 0, 0, 0, 0, 1, 2'b10, 32'h8000_0000);
        step(9'd0, 0, 0, 0, 0, 0, 0, 2'b00, 0);
        step(9'd0, 1, 0, 0, 0, 0, 0, 2'b00, 0);
        step(9'd256, 1, 1, 0, 0, 0, 0, 2'b00, 0);
        // mode 3 never requests
        step(9'd0, 0, 0, 0, 0, 0, 1, 2'b10, 32'hC000_0000);
        step(9'd0, 0, 0, 0, 0, 0, 0, 2'b00, 0);
        // R6/R7 set, ignored clear, clear, set wins
        step(9'd3, 0, 0, 1, 1, 1, 0, 2'b00, 0);
        step(9'd3, 0, 0, 0, 0, 0, 1, 2'b01, 32'h0000_7FFF);
        step(9'd3, 0, 0, 0, 0, 0, 1, 2'b10, 32'h0000_8000);
        step(9'd3, 0, 0, 0, 0, 0, 1, 2'b01, 32'h0000_8000);
        step(9'd3, 0, 0, 1, 1, 1, 1, 2'b01, 32'h0000_8000);
        step(9'd3, 0, 0, 0, 0, 0, 1, 2'b11, 32'h0000_8000);
        for (int i = 0; i < 400; i++) begin
            logic [8:0] qc;
            int sel = $urandom_range(0, 9);
            qc = (sel == 0) ? 9'd0 : (sel == 1) ? 9'd127 : (sel == 2) ? 9'd128 :
                 9'($urandom_range(0, 256));
            step(qc, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
                 2'($urandom_range(0, 3)), $urandom);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule